// File: doc/BRIEF.md
# DMA channel RAM address counter

This block keeps the RAM-side address for two DMA channels. Each channel owns a 16-bit register holding the low 16 bits of a RAM address. Software loads it through a small register port, either as a whole word or one byte lane at a time. A channel in transfer uses the loaded value as the address of its first element. After each element the register moves forward by one in byte mode or by two in halfword mode.

Each channel presents an effective bus address at all times. In halfword mode bit 0 of the register is masked to zero, so every halfword access lands on an even address. The stored bit 0 is left as it is and still reads back unchanged.

Every clock edge, each channel performs one of three operations. HOLD keeps the value. LOAD merges the enabled write lanes into the value. STEP adds the mode's step size. STEP is taken when the channel's transfer is active and its element-done strobe is high. LOAD is taken when the register port addresses the channel while its transfer is inactive. HOLD is taken in every other case. A write that arrives while the channel is active goes to HOLD, or to STEP if the strobe is also high, so the increment always wins over a write.

Top module: `dra_addr_ctr`

## Requirements
- R1: An active-low reset, applied asynchronously, sets both channel registers to 0x0000.
- R2: With `cpu_wr` high, `cpu_be` = 2'b11 and `xfer_active` low for the channel selected by `cpu_sel` (0 or 1), the register takes `cpu_wdata` at the clock edge. The other channel does not change.
- R3: Byte lanes: `cpu_be[0]` writes register bits 7:0 and `cpu_be[1]` writes bits 15:8. A lane that is not enabled keeps its old byte, and `cpu_be` = 2'b00 changes nothing.
- R4: While a channel's `xfer_active` bit is high, CPU writes to that channel are ignored. This also holds when a write and an increment fall in the same cycle: the increment is applied and the write data is discarded.
- R5: In byte mode (`half_mode[n]` = 0), a clock edge with both `elem_done[n]` and `xfer_active[n]` high adds 1 to the register. The new value is visible after that edge.
- R6: In halfword mode (`half_mode[n]` = 1), the same event adds 2 to the stored value, and stored bit 0 is carried through unchanged.
- R7: `ram_addr[16n+15:16n]` is the effective address of channel n. It equals the register in byte mode and the register with bit 0 cleared in halfword mode. It follows the register and the mode without a clock delay.
- R8: `elem_done[n]` has no effect while `xfer_active[n]` is low.
- R9: Increments wrap modulo 2^16: 0xFFFF+1 gives 0x0000, and 0xFFFF+2 gives 0x0001.
- R10: `cpu_rdata` returns the raw register of the channel chosen by `cpu_sel`, including bit 0, without a clock delay.
- R11: The channels are independent: the strobe, mode and active inputs of one channel never change the other channel's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write request |
| cpu_sel | input | 1 | Channel selected for write and readback |
| cpu_be | input | 2 | Byte-lane enables (bit 0 low byte, bit 1 high byte) |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Readback of the selected channel register |
| xfer_active | input | 2 | Per-channel transfer in progress |
| half_mode | input | 2 | Per-channel halfword mode (1) or byte mode (0) |
| elem_done | input | 2 | Per-channel element-done strobe |
| ram_addr | output | 32 | Effective addresses, channel n in bits 16n+15:16n |

## Verification
Register changes from LOAD and STEP appear one edge after the stimulus. Readback and the effective address are combinational, so they follow the register within that same cycle. The bench drives inputs at a falling edge, lets exactly one rising edge pass, and then drops the write and strobe inputs at the next falling edge. It then reads both channels through `cpu_sel`, with a short settling delay after each selection. Asynchronous reset is checked a fraction of a cycle after it is applied, with no edge in between. A multi-cycle strobe burst is checked after counting the edges it spans.

// File: rtl/dra_pkg.sv
package dra_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } chan_op_e;
endpackage

// File: rtl/dra_lane_merge.sv
module dra_lane_merge #(
    parameter int AW = 16,
    localparam int NB = AW / 8
) (
    input  logic [AW-1:0] old_val,
    input  logic [AW-1:0] new_val,
    input  logic [NB-1:0] lane_en,
    output logic [AW-1:0] merged
);
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[b*8 +: 8] = lane_en[b] ? new_val[b*8 +: 8] : old_val[b*8 +: 8];
    end
endmodule

// File: rtl/dra_chan.sv
module dra_chan
    import dra_pkg::*;
#(
    parameter int AW = 16,
    localparam int NB = AW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  logic [NB-1:0] be,
    input  logic [AW-1:0] wdata,
    input  logic          active,
    input  logic          half,
    input  logic          done,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] eff_addr
);
    chan_op_e      op;
    logic [AW-1:0] merged;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] step;

    dra_lane_merge #(.AW(AW)) u_merge (
        .old_val (addr_q),
        .new_val (wdata),
        .lane_en (be),
        .merged  (merged)
    );

    assign step = half ? AW'(2) : AW'(1);

    // operation select: the increment outranks any write
    always_comb begin
        if (active && done)
            op = OP_STEP;
        else if (wr_hit && !active)
            op = OP_LOAD;
        else
            op = OP_HOLD;
    end

    always_comb begin
        unique case (op)
            OP_STEP: addr_d = addr_q + step;
            OP_LOAD: addr_d = merged;
            default: addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    assign eff_addr = half ? {addr_q[AW-1:1], 1'b0} : addr_q;

    assert_step_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && done && !half) |=> addr_q == $past(addr_q) + AW'(1));

    assert_step_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && done && half) |=> addr_q == $past(addr_q) + AW'(2));

    assert_wr_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> $stable(addr_q));

    assert_idle_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !wr_hit) |=> $stable(addr_q));

    assert_word_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !active && (&be)) |=> addr_q == $past(wdata));
endmodule

// File: rtl/dra_rd_mux.sv
module dra_rd_mux #(
    parameter int AW   = 16,
    parameter int NCH  = 2,
    parameter int SELW = 1
) (
    input  logic [NCH*AW-1:0] regs,
    input  logic [SELW-1:0]   sel,
    output logic [AW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == SELW'(i))
                rdata = regs[i*AW +: AW];
        end
    end
endmodule

// File: rtl/dra_addr_ctr.sv
module dra_addr_ctr #(
    parameter int NCH = 2,
    parameter int AW  = 16,
    localparam int NB   = AW / 8,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [SELW-1:0]   cpu_sel,
    input  logic [NB-1:0]     cpu_be,
    input  logic [AW-1:0]     cpu_wdata,
    output logic [AW-1:0]     cpu_rdata,
    input  logic [NCH-1:0]    xfer_active,
    input  logic [NCH-1:0]    half_mode,
    input  logic [NCH-1:0]    elem_done,
    output logic [NCH*AW-1:0] ram_addr
);
    logic [NCH*AW-1:0] regs;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic hit;
        assign hit = cpu_wr && (cpu_sel == SELW'(n));

        dra_chan #(.AW(AW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .be       (cpu_be),
            .wdata    (cpu_wdata),
            .active   (xfer_active[n]),
            .half     (half_mode[n]),
            .done     (elem_done[n]),
            .addr_q   (regs[n*AW +: AW]),
            .eff_addr (ram_addr[n*AW +: AW])
        );

        assert_even_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            half_mode[n] |-> (ram_addr[n*AW] == 1'b0));

        assert_upper_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ram_addr[n*AW+1 +: AW-1] == regs[n*AW+1 +: AW-1]);
    end

    dra_rd_mux #(.AW(AW), .NCH(NCH), .SELW(SELW)) u_rd (
        .regs  (regs),
        .sel   (cpu_sel),
        .rdata (cpu_rdata)
    );
endmodule

// File: tb/dra_addr_ctr_tb.sv
module dra_addr_ctr_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_wr;
    logic [0:0]  cpu_sel;
    logic [1:0]  cpu_be;
    logic [15:0] cpu_wdata;
    logic [15:0] cpu_rdata;
    logic [1:0]  xfer_active;
    logic [1:0]  half_mode;
    logic [1:0]  elem_done;
    logic [31:0] ram_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dra_addr_ctr u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_sel     (cpu_sel),
        .cpu_be      (cpu_be),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .xfer_active (xfer_active),
        .half_mode   (half_mode),
        .elem_done   (elem_done),
        .ram_addr    (ram_addr)
    );

    // {wr, sel, be, wdata, active, half, done, exp_ch0, exp_ch1, req}
    localparam int NV = 16;
    localparam logic [61:0] VEC [NV] = '{
        {1'b1,1'b0,2'b11,16'h1234,2'b00,2'b00,2'b00,16'h1234,16'h0000,4'd2},  // R2 word ch0
        {1'b1,1'b1,2'b11,16'hABCD,2'b00,2'b00,2'b00,16'h1234,16'hABCD,4'd2},  // R2 word ch1
        {1'b1,1'b0,2'b01,16'h00FF,2'b00,2'b00,2'b00,16'h12FF,16'hABCD,4'd3},  // R3 low lane
        {1'b1,1'b1,2'b10,16'h5500,2'b00,2'b00,2'b00,16'h12FF,16'h55CD,4'd3},  // R3 high lane
        {1'b1,1'b0,2'b00,16'hFFFF,2'b00,2'b00,2'b00,16'h12FF,16'h55CD,4'd3},  // R3 no lane
        {1'b0,1'b0,2'b00,16'h0000,2'b01,2'b00,2'b01,16'h1300,16'h55CD,4'd5},  // R5 byte step carry
        {1'b0,1'b0,2'b00,16'h0000,2'b01,2'b01,2'b01,16'h1302,16'h55CD,4'd6},  // R6 halfword step
        {1'b1,1'b0,2'b11,16'h7777,2'b01,2'b00,2'b00,16'h1302,16'h55CD,4'd4},  // R4 write blocked
        {1'b1,1'b0,2'b11,16'h7777,2'b01,2'b00,2'b01,16'h1303,16'h55CD,4'd4},  // R4 step beats write
        {1'b0,1'b0,2'b00,16'h0000,2'b00,2'b00,2'b11,16'h1303,16'h55CD,4'd8},  // R8 strobe idle
        {1'b0,1'b0,2'b00,16'h0000,2'b10,2'b10,2'b10,16'h1303,16'h55CF,4'd11}, // R11 R6 R10 odd raw
        {1'b1,1'b1,2'b11,16'hFFFF,2'b00,2'b00,2'b00,16'h1303,16'hFFFF,4'd2},
        {1'b0,1'b0,2'b00,16'h0000,2'b10,2'b00,2'b10,16'h1303,16'h0000,4'd9},  // R9 byte wrap
        {1'b1,1'b1,2'b11,16'hFFFF,2'b00,2'b00,2'b00,16'h1303,16'hFFFF,4'd2},
        {1'b0,1'b0,2'b00,16'h0000,2'b10,2'b10,2'b10,16'h1303,16'h0001,4'd9},  // R9 halfword wrap
        {1'b1,1'b0,2'b11,16'h0000,2'b10,2'b00,2'b00,16'h0000,16'h0001,4'd11}  // R11 ch0 free
    };

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // readback (R10) and effective address (R7) of both channels
    task automatic read_both(input int req, input logic [15:0] e0, input logic [15:0] e1);
        logic [15:0] b0, b1;
        b0 = half_mode[0] ? {e0[15:1], 1'b0} : e0;
        b1 = half_mode[1] ? {e1[15:1], 1'b0} : e1;
        cpu_sel = 1'b0;
        #1;
        check(req, "ch0 readback", cpu_rdata, e0);
        check(req, "ch0 ram_addr", ram_addr[15:0], b0);
        cpu_sel = 1'b1;
        #1;
        check(req, "ch1 readback", cpu_rdata, e1);
        check(req, "ch1 ram_addr", ram_addr[31:16], b1);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_wr = 1'b0; cpu_sel = 1'b0; cpu_be = 2'b00; cpu_wdata = '0;
        xfer_active = '0; half_mode = '0; elem_done = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_both(1, 16'h0000, 16'h0000);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            logic [61:0] v;
            v = VEC[i];
            cpu_wr      = v[61];
            cpu_sel     = v[60];
            cpu_be      = v[59:58];
            cpu_wdata   = v[57:42];
            xfer_active = v[41:40];
            half_mode   = v[39:38];
            elem_done   = v[37:36];
            @(negedge clk);
            cpu_wr    = 1'b0;
            elem_done = 2'b00;
            read_both(int'(v[3:0]), v[35:20], v[19:4]);
        end

        // R1: asynchronous reset mid-run, checked without a clock edge
        @(negedge clk);
        xfer_active = '0; half_mode = '0;
        cpu_wr = 1'b1; cpu_sel = 1'b1; cpu_be = 2'b11; cpu_wdata = 16'h4321;
        @(negedge clk);
        cpu_wr = 1'b0;
        rst_n = 1'b0;
        #1;
        read_both(1, 16'h0000, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: strobe held for three edges in byte mode
        xfer_active = 2'b01; elem_done = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        elem_done = 2'b00;
        read_both(5, 16'h0003, 16'h0000);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule